// File: doc/BRIEF.md
# 1-Wire Data Transfer Command Handler

This block is the function-level command stage of a 1-Wire coprocessor slave. It sits behind a byte-level 1-Wire interface and starts working once addressing at ROM level has finished. After every bus reset it treats the next received byte as a function command. It then carries out that command's transfer.

The commands are:
- writes into and reads from a 128-byte intermediate product register;
- a length-prefixed write into an I/O input buffer;
- a status read, whose first byte is the free space left in the input buffer;
- a single-byte write of the UART status byte;
- a guarded program start that fires only after a two-byte release code.

Both storage regions sit outside the block, behind a single memory port that has a region select. A read uses the memory's combinational read data. A transmit byte is offered on `tx_data` and advances each time the byte layer pulses `tx_pull`. Once a command has completed, or has been rejected, the block does nothing more until the next bus reset.

Top module: `owcmd_handler`

## Requirements
- R1: After `rst_n` is low at a clock edge, the block waits for a command. `tx_data` reads FFh, the UART status byte is 00h, the buffer fill is 0, and `run_start` is low.
- R2: Command 0Fh writes each following received byte to the intermediate product register (`mem_sel`=0). The writes go to addresses 0, 1, 2, … and `mem_we` is high in the same cycle as the byte's `rx_valid`.
- R3: Bytes received after command 0Fh beyond `IPR_DEPTH` bytes cause no write.
- R4: Command AAh presents the register byte at address 0 on `tx_data`. Each `tx_pull` advances to the next address. After `IPR_DEPTH` bytes, `tx_data` reads FFh.
- R5: Command 2Dh takes a length byte L, then L data bytes, which are written to the input buffer (`mem_sel`=1) at addresses 0, 1, …. After the L-th data byte the block halts, and further bytes cause no write.
- R6: Data bytes beyond `IOB_DEPTH` are not written. On completion the buffer fill becomes min(L, `IOB_DEPTH`). A length of 0 sets the fill to 0 at once.
- R7: Command E1h presents three bytes in this order, advancing on each `tx_pull`: `IOB_DEPTH` minus the fill, then the UART status byte, then `cpu_status`. After those three bytes it presents FFh.
- R8: Command D2h loads the next byte into the UART status byte. Later bytes are ignored until a bus reset.
- R9: Command 77h followed by 43h and then 6Dh raises `run_start` for exactly the cycle of the 6Dh byte.
- R10: An unknown command byte, or a wrong release byte, causes no write, no start and no status change. `tx_data` then reads FFh until the next bus reset.
- R11: `bus_reset` aborts any transfer. The next command restarts at address 0. An aborted 2Dh transfer leaves the previous fill unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | 1-Wire reset pulse seen by the byte layer |
| rx_valid | input | 1 | One-cycle strobe: a byte arrived from the master |
| rx_data | input | 8 | Received byte |
| tx_pull | input | 1 | One-cycle strobe: the byte layer consumed `tx_data` |
| tx_data | output | 8 | Byte offered to the master |
| mem_we | output | 1 | Memory write enable |
| mem_sel | output | 1 | Region: 0 register, 1 input buffer |
| mem_addr | output | MAW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data (combinational) |
| cpu_status | input | 8 | Processor status byte for status reads |
| run_start | output | 1 | Program start strobe |

## Verification
The bench builds the block with `IPR_DEPTH`=16 and `IOB_DEPTH`=8. With these depths, a few dozen bytes are enough to reach both saturation limits: the 17th register byte and the ninth buffer byte. They also let random lengths from 0 to 12 land on both sides of the buffer cap. As a result, a full fill and a zero fill both show up in the free-space status byte.

// File: rtl/owcmd_pkg.sv
// Shared types and command codes for the 1-Wire data transfer command handler.
package owcmd_pkg;

    typedef enum logic [3:0] {
        ST_CMD,       // waiting for a function command byte
        ST_IPR_WR,    // streaming bytes into the product register
        ST_IPR_RD,    // streaming product register bytes out
        ST_IOB_LEN,   // waiting for the input buffer length byte
        ST_IOB_DATA,  // streaming bytes into the input buffer
        ST_STAT_RD,   // offering status bytes
        ST_STAT_WR,   // waiting for the UART status byte
        ST_REL_LO,    // waiting for the first release byte
        ST_REL_HI,    // waiting for the second release byte
        ST_HALT       // finished or rejected; wait for bus reset
    } ow_state_t;

    localparam logic [7:0] CMD_IPR_WRITE  = 8'h0F;
    localparam logic [7:0] CMD_IPR_READ   = 8'hAA;
    localparam logic [7:0] CMD_IOB_WRITE  = 8'h2D;
    localparam logic [7:0] CMD_STAT_READ  = 8'hE1;
    localparam logic [7:0] CMD_STAT_WRITE = 8'hD2;
    localparam logic [7:0] CMD_RUN        = 8'h77;
    localparam logic [7:0] REL_LO_CODE    = 8'h43;
    localparam logic [7:0] REL_HI_CODE    = 8'h6D;
    localparam logic [7:0] IDLE_BYTE      = 8'hFF;

endpackage

// File: rtl/owcmd_xfer_ctr.sv
// Byte pointer for all transfers of the command handler.
// Counts up on inc, saturates at LIMIT, clears on clr (clr wins).
// Assumes CW is wide enough to hold LIMIT.
module owcmd_xfer_ctr #(
    parameter int LIMIT = 255,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    // Saturating up-counter with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CW'(LIMIT))) begin
            count <= count + 1'b1;
        end
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(LIMIT));

    // R11
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/owcmd_status.sv
// Status storage of the command handler: the UART status byte written by
// the master and the input buffer fill count. Selects the status byte
// offered for a given read index. Assumes IOB_DEPTH <= 255.
module owcmd_status #(
    parameter int IOB_DEPTH = 128,
    parameter int PCW       = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           uart_wr,
    input  logic [7:0]     wdata,
    input  logic           fill_set,
    input  logic [7:0]     fill_val,
    input  logic [PCW-1:0] idx,
    input  logic [7:0]     cpu_status,
    output logic [7:0]     rd_byte
);

    localparam int FW = $clog2(IOB_DEPTH + 1);

    logic [7:0]    uart_q;
    logic [FW-1:0] fill_q;
    logic [7:0]    free_bytes;

    // UART status byte register, loaded only by the status write command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uart_q <= 8'h00;
        end else if (uart_wr) begin
            uart_q <= wdata;
        end
    end

    // Input buffer fill, committed when a buffer write completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (fill_set) begin
            fill_q <= fill_val[FW-1:0];
        end
    end

    // Free space left in the input buffer.
    always_comb begin
        free_bytes = 8'(IOB_DEPTH) - 8'(fill_q);
    end

    // Status byte order: free space, UART status, processor status, then idle.
    always_comb begin
        if (idx == PCW'(0)) begin
            rd_byte = free_bytes;
        end else if (idx == PCW'(1)) begin
            rd_byte = uart_q;
        end else if (idx == PCW'(2)) begin
            rd_byte = cpu_status;
        end else begin
            rd_byte = owcmd_pkg::IDLE_BYTE;
        end
    end

    // R8
    uart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uart_wr |=> (uart_q == $past(wdata)));

    // R6
    fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FW'(IOB_DEPTH));

endmodule

// File: rtl/owcmd_fsm.sv
// Command sequencer of the handler. Decodes the function command byte,
// tracks the transfer phase, and produces write enables, the fill update
// and the start strobe. Assumes the byte layer delivers only function-level
// bytes after each bus reset, and that bus_reset takes priority over rx_valid.
module owcmd_fsm
    import owcmd_pkg::*;
#(
    parameter int IPR_DEPTH = 128,
    parameter int IOB_DEPTH = 128,
    parameter int PCW       = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_reset,
    input  logic           rx_valid,
    input  logic [7:0]     rx_data,
    input  logic           tx_pull,
    input  logic [PCW-1:0] ptr,
    output ow_state_t      state,
    output logic           ptr_clr,
    output logic           ptr_inc,
    output logic           mem_we,
    output logic           mem_sel,
    output logic           uart_wr,
    output logic           fill_set,
    output logic [7:0]     fill_val,
    output logic           run_start
);

    ow_state_t  state_nx;
    logic [7:0] len_q;
    logic       rx_ok;
    logic       ipr_room;
    logic       iob_room;
    logic       iob_last;
    logic [PCW-1:0] ptr_nx;

    // Qualified receive strobe: a bus reset discards a coincident byte.
    always_comb begin
        rx_ok    = rx_valid && !bus_reset;
        ptr_nx   = ptr + 1'b1;
        ipr_room = ptr < PCW'(IPR_DEPTH);
        iob_room = ptr < PCW'(IOB_DEPTH);
        iob_last = ptr_nx == PCW'(len_q);
    end

    // Pointer control: clear at each command or length byte, step per byte.
    always_comb begin
        ptr_clr = bus_reset ||
                  (rx_valid && ((state == ST_CMD) || (state == ST_IOB_LEN)));
        ptr_inc = !bus_reset &&
                  ((rx_valid && ((state == ST_IPR_WR) || (state == ST_IOB_DATA))) ||
                   (tx_pull  && ((state == ST_IPR_RD) || (state == ST_STAT_RD))));
    end

    // Side-effect strobes for memory, status and program start.
    always_comb begin
        mem_sel   = (state == ST_IOB_DATA);
        mem_we    = rx_ok && (((state == ST_IPR_WR) && ipr_room) ||
                              ((state == ST_IOB_DATA) && iob_room));
        uart_wr   = rx_ok && (state == ST_STAT_WR);
        run_start = rx_ok && (state == ST_REL_HI) && (rx_data == REL_HI_CODE);
        fill_set  = rx_ok && (((state == ST_IOB_LEN) && (rx_data == 8'h00)) ||
                              ((state == ST_IOB_DATA) && iob_last));
        if (state == ST_IOB_LEN) begin
            fill_val = 8'h00;
        end else if (len_q > 8'(IOB_DEPTH)) begin
            fill_val = 8'(IOB_DEPTH);
        end else begin
            fill_val = len_q;
        end
    end

    // Next-state decode on each received byte.
    always_comb begin
        state_nx = state;
        if (bus_reset) begin
            state_nx = ST_CMD;
        end else if (rx_valid) begin
            unique case (state)
                ST_CMD: begin
                    unique case (rx_data)
                        CMD_IPR_WRITE:  state_nx = ST_IPR_WR;
                        CMD_IPR_READ:   state_nx = ST_IPR_RD;
                        CMD_IOB_WRITE:  state_nx = ST_IOB_LEN;
                        CMD_STAT_READ:  state_nx = ST_STAT_RD;
                        CMD_STAT_WRITE: state_nx = ST_STAT_WR;
                        CMD_RUN:        state_nx = ST_REL_LO;
                        default:        state_nx = ST_HALT;
                    endcase
                end
                ST_IOB_LEN:  state_nx = (rx_data == 8'h00) ? ST_HALT : ST_IOB_DATA;
                ST_IOB_DATA: state_nx = iob_last ? ST_HALT : ST_IOB_DATA;
                ST_STAT_WR:  state_nx = ST_HALT;
                ST_REL_LO:   state_nx = (rx_data == REL_LO_CODE) ? ST_REL_HI : ST_HALT;
                ST_REL_HI:   state_nx = ST_HALT;
                default:     state_nx = state;
            endcase
        end
    end

    // State and length registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CMD;
            len_q <= 8'h00;
        end else begin
            state <= state_nx;
            if (rx_ok && (state == ST_IOB_LEN)) begin
                len_q <= rx_data;
            end
        end
    end

    // R9
    start_then_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> (state == ST_HALT));

    // R9
    release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |-> ($past(state) == ST_REL_LO));

    // R11
    reset_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (state == ST_CMD));

    // R5
    iob_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_set && (state == ST_IOB_DATA)) |=> (state == ST_HALT));

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HALT) && !bus_reset) |=> (state == ST_HALT));

endmodule

// File: rtl/owcmd_handler.sv
// Top of the 1-Wire data transfer command handler. Connects the command
// sequencer, the shared byte pointer and the status storage, and forms the
// memory port and the transmit byte. Assumes mem_rdata is combinational from
// mem_sel/mem_addr and IOB_DEPTH <= 255.
module owcmd_handler
    import owcmd_pkg::*;
#(
    parameter int IPR_DEPTH = 128,
    parameter int IOB_DEPTH = 128,
    parameter int MAX_DEPTH = (IPR_DEPTH > IOB_DEPTH) ? IPR_DEPTH : IOB_DEPTH,
    parameter int MAW       = $clog2(MAX_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_reset,
    input  logic           rx_valid,
    input  logic [7:0]     rx_data,
    input  logic           tx_pull,
    output logic [7:0]     tx_data,
    output logic           mem_we,
    output logic           mem_sel,
    output logic [MAW-1:0] mem_addr,
    output logic [7:0]     mem_wdata,
    input  logic [7:0]     mem_rdata,
    input  logic [7:0]     cpu_status,
    output logic           run_start
);

    localparam int PTR_LIMIT = (IPR_DEPTH > 255) ? IPR_DEPTH : 255;
    localparam int PCW       = $clog2(PTR_LIMIT + 1);

    ow_state_t      state;
    logic [PCW-1:0] ptr;
    logic           ptr_clr;
    logic           ptr_inc;
    logic           uart_wr;
    logic           fill_set;
    logic [7:0]     fill_val;
    logic [7:0]     stat_byte;

    owcmd_fsm #(
        .IPR_DEPTH (IPR_DEPTH),
        .IOB_DEPTH (IOB_DEPTH),
        .PCW       (PCW)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tx_pull   (tx_pull),
        .ptr       (ptr),
        .state     (state),
        .ptr_clr   (ptr_clr),
        .ptr_inc   (ptr_inc),
        .mem_we    (mem_we),
        .mem_sel   (mem_sel),
        .uart_wr   (uart_wr),
        .fill_set  (fill_set),
        .fill_val  (fill_val),
        .run_start (run_start)
    );

    owcmd_xfer_ctr #(
        .LIMIT (PTR_LIMIT),
        .CW    (PCW)
    ) ptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ptr_clr),
        .inc   (ptr_inc),
        .count (ptr)
    );

    owcmd_status #(
        .IOB_DEPTH (IOB_DEPTH),
        .PCW       (PCW)
    ) stat_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .uart_wr    (uart_wr),
        .wdata      (rx_data),
        .fill_set   (fill_set),
        .fill_val   (fill_val),
        .idx        (ptr),
        .cpu_status (cpu_status),
        .rd_byte    (stat_byte)
    );

    // Memory address and data come straight from the pointer and receive byte.
    always_comb begin
        mem_addr  = ptr[MAW-1:0];
        mem_wdata = rx_data;
    end

    // Transmit byte: register data, status bytes, or the idle pattern.
    always_comb begin
        if (state == ST_IPR_RD) begin
            tx_data = (ptr < PCW'(IPR_DEPTH)) ? mem_rdata : IDLE_BYTE;
        end else if (state == ST_STAT_RD) begin
            tx_data = stat_byte;
        end else begin
            tx_data = IDLE_BYTE;
        end
    end

    // R2
    ipr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_sel) |-> (int'(mem_addr) < IPR_DEPTH));

    // R6
    iob_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_sel) |-> (int'(mem_addr) < IOB_DEPTH));

    // R4
    read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IPR_RD) && tx_pull && !bus_reset && (ptr < PCW'(IPR_DEPTH)))
        |=> (ptr == $past(ptr) + 1'b1));

endmodule

// File: tb/owcmd_handler_tb_top.sv
`timescale 1ns/1ps
module owcmd_handler_tb_top;

    localparam int IPR_D = 16;
    localparam int IOB_D = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_pull = 1'b0;
    logic [7:0] tx_data;
    logic       mem_we;
    logic       mem_sel;
    logic [3:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic [7:0] cpu_status = 8'h3C;
    logic       run_start;

    logic [7:0] ipr_m [IPR_D];
    logic [7:0] iob_m [IOB_D];
    logic [7:0] exp_ipr [IPR_D];
    logic [7:0] exp_iob [IOB_D];

    int checks = 0;
    int fails = 0;
    int wr_ipr = 0;
    int wr_iob = 0;
    int starts = 0;
    int exp_fill = 0;
    logic       last_we;
    logic       last_sel;
    logic [3:0] last_addr;
    logic       last_start;
    logic [7:0] b;
    int         seed_dummy;

    always #2 clk = ~clk;

    assign mem_rdata = mem_sel ? iob_m[mem_addr[2:0]] : ipr_m[mem_addr];

    owcmd_handler #(.IPR_DEPTH(IPR_D), .IOB_DEPTH(IOB_D)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_pull(tx_pull),
        .tx_data(tx_data), .mem_we(mem_we), .mem_sel(mem_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cpu_status(cpu_status), .run_start(run_start)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int min_fill(input int len);
        return (len > IOB_D) ? IOB_D : len;
    endfunction

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = d;
        #1;
        last_we = mem_we; last_sel = mem_sel; last_addr = mem_addr; last_start = run_start;
        if (mem_we) begin
            if (mem_sel) begin iob_m[mem_addr[2:0]] = mem_wdata; wr_iob++; end
            else begin ipr_m[mem_addr] = mem_wdata; wr_ipr++; end
        end
        if (run_start) starts++;
        @(posedge clk);
        #1;
        rx_valid = 1'b0;
    endtask

    task automatic pull(output logic [7:0] v);
        @(negedge clk);
        v = tx_data;
        tx_pull = 1'b1;
        @(posedge clk);
        #1;
        tx_pull = 1'b0;
    endtask

    task automatic bus_rst();
        @(negedge clk);
        bus_reset = 1'b1;
        @(posedge clk);
        #1;
        bus_reset = 1'b0;
    endtask

    task automatic stat_expect(input int fill, input logic [7:0] uart, input string tag);
        logic [7:0] v;
        bus_rst();
        send(8'hE1);
        pull(v); chk(v, 32'(IOB_D - fill), {tag, " R7 free"});
        pull(v); chk(v, uart, {tag, " R7 uart"});
        pull(v); chk(v, cpu_status, {tag, " R7 cpu"});
        pull(v); chk(v, 8'hFF, {tag, " R7 idle"});
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h1A2B);
        for (int i = 0; i < IPR_D; i++) ipr_m[i] = 8'h00;
        for (int i = 0; i < IOB_D; i++) iob_m[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk(tx_data, 8'hFF, "R1 idle tx");
        chk(run_start, 0, "R1 no start");
        rst_n = 1'b1;
        // R1 reset status: empty buffer, zero UART byte
        stat_expect(0, 8'h00, "R1");

        // R2 R4 random register write and read back
        for (int rep = 0; rep < 4; rep++) begin
            int n;
            n = 1 + ($urandom % IPR_D);
            bus_rst();
            send(8'h0F);
            wr_ipr = 0;
            for (int i = 0; i < n; i++) begin
                exp_ipr[i] = 8'($urandom);
                send(exp_ipr[i]);
                chk(last_addr, i, "R2 addr");
                chk(last_we & ~last_sel, 1, "R2 we");
            end
            chk(wr_ipr, n, "R2 count");
            bus_rst();
            send(8'hAA);
            for (int i = 0; i < n; i++) begin
                pull(b);
                chk(b, exp_ipr[i], "R4 data");
            end
        end

        // R3 overflow of register write
        bus_rst();
        send(8'h0F);
        wr_ipr = 0;
        for (int i = 0; i < IPR_D + 4; i++) send(8'(8'h40 + i));
        chk(wr_ipr, IPR_D, "R3 write count");
        for (int i = 0; i < IPR_D; i++) exp_ipr[i] = 8'(8'h40 + i);
        bus_rst();
        send(8'hAA);
        for (int i = 0; i < IPR_D; i++) begin
            pull(b);
            chk(b, exp_ipr[i], "R3 R4 data");
        end
        pull(b); chk(b, 8'hFF, "R4 past end");

        // R5 directed buffer write of 5 bytes
        bus_rst();
        send(8'h2D); send(8'd5);
        wr_iob = 0;
        for (int i = 0; i < 5; i++) begin
            exp_iob[i] = 8'(8'hA0 + i);
            send(exp_iob[i]);
            chk(last_addr, i, "R5 addr");
        end
        chk(wr_iob, 5, "R5 count");
        send(8'h77); chk(last_we, 0, "R5 halt after last");
        for (int i = 0; i < 5; i++) chk(iob_m[i], exp_iob[i], "R5 data");
        exp_fill = 5;
        stat_expect(exp_fill, 8'h00, "R5");

        // R6 random lengths, some above the buffer depth, plus zero
        for (int rep = 0; rep < 5; rep++) begin
            int len;
            len = (rep == 4) ? 0 : ($urandom % 13);
            bus_rst();
            send(8'h2D); send(8'(len));
            wr_iob = 0;
            for (int i = 0; i < len; i++) send(8'($urandom));
            send(8'h5A);
            chk(wr_iob, min_fill(len), "R6 count");
            exp_fill = min_fill(len);
            stat_expect(exp_fill, 8'h00, "R6");
        end
        bus_rst();
        send(8'h2D); send(8'd12);
        wr_iob = 0;
        for (int i = 0; i < 12; i++) send(8'(i));
        chk(wr_iob, IOB_D, "R6 cap count");
        exp_fill = IOB_D;
        stat_expect(exp_fill, 8'h00, "R6 full");

        // R8 UART status write, second byte ignored
        bus_rst();
        send(8'hD2); send(8'hA5); send(8'h5A);
        chk(last_we, 0, "R8 no write");
        stat_expect(exp_fill, 8'hA5, "R8");

        // R9 correct release sequence
        starts = 0;
        bus_rst();
        send(8'h77); send(8'h43);
        chk(last_start, 0, "R9 not on low byte");
        send(8'h6D);
        chk(last_start, 1, "R9 start");
        chk(starts, 1, "R9 one start");

        // R10 wrong orders and unknown command
        bus_rst(); send(8'h77); send(8'h6D); send(8'h43);
        chk(starts, 1, "R10 swapped release");
        bus_rst(); send(8'h77); send(8'h43); send(8'h00); send(8'h6D);
        chk(starts, 1, "R10 bad high byte");
        bus_rst(); send(8'h55); send(8'h0F); send(8'h11);
        chk(last_we, 0, "R10 unknown cmd no write");
        #1; chk(tx_data, 8'hFF, "R10 idle tx");
        send(8'hD2); send(8'h99);
        stat_expect(exp_fill, 8'hA5, "R10 status kept");

        // R11 aborted register write restarts at address 0
        bus_rst(); send(8'h0F); send(8'h01); send(8'h02); send(8'h03);
        bus_rst(); send(8'h0F); send(8'h99);
        chk(last_addr, 0, "R11 restart addr");
        exp_ipr[0] = 8'h99; exp_ipr[1] = 8'h02;
        bus_rst(); send(8'hAA); pull(b); pull(b);
        bus_rst(); send(8'hAA); pull(b);
        chk(b, exp_ipr[0], "R11 read restart");
        pull(b); chk(b, exp_ipr[1], "R11 read second");
        // R11 aborted buffer write keeps previous fill
        bus_rst(); send(8'h2D); send(8'd3); send(8'h10); send(8'h11); send(8'h12);
        exp_fill = 3;
        bus_rst(); send(8'h2D); send(8'd6); send(8'h20); send(8'h21);
        stat_expect(exp_fill, 8'hA5, "R11 abort fill");
        chk(starts, 1, "R10 no stray start");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule